// File: doc/BRIEF.md
# Serial Configuration Register File

This block is the control store of an image-sensor front end. A host writes configuration words over a three-wire serial link made of a load strobe, a serial clock and a serial data line. These three lines share pads with the top bits of the pixel output bus. The link is only listened to while the line-sync input is high. During that time the block tells the pad ring to release the bus. All three serial lines are sampled in the system clock domain through a synchronizer. Edges are found by comparing each sample with the one before it.

A frame has eleven bits: a three-bit register address followed by eight data bits, both sent most significant bit first. The block decodes each frame into eight registers:

- a six-bit gain for each of three colour channels;
- an eight-bit offset for each of the three colour channels;
- a mode register;
- a mode/test register.

The register contents drive named control outputs. A mode write can restore every register to its power-up value. Leaving power-down discards the signal-configuration field of that write.

Top module: `ctl_regfile_top`

## Requirements
- R1: After reset, all three gains read 0 and all three offsets read 0x40. Every mode output and every test output reads 0.
- R2: A frame starts on a falling load strobe while line sync is high. One bit is taken on each rising serial clock, MSB first: address bits a2 a1 a0, then data bits d7 down to d0. The write takes effect on the rising load strobe and appears at the outputs within 12 system clocks.
- R3: Colour c (0 red, 1 green, 2 blue) has its gain at address 2c and its offset at address 2c+1. A gain takes data bits d7..d2, and d1..d0 are dropped. An offset takes all eight data bits. Within the packed outputs, colour c occupies slice c.
- R4: A frame with fewer than eleven rising serial clocks before the load strobe rises changes no register.
- R5: Serial clocks after the eleventh in a frame are ignored, so only the first eleven bits are used.
- R6: A frame sent while line sync is low is ignored. A frame during which line sync falls is discarded. bus_oe_o is 0 whenever line sync is high.
- R7: Address 6 is the mode register. Its fields are: d7 power-down, d5 external top reference, d4 external DC reference, d3 AC coupling, d2 inverted polarity, and d1..d0 signal configuration.
- R8: Address 7 is the test register. Its fields are: d6 output disable, d5 offset range, d4 internal reference enable, and d3..d0 test enables. bus_oe_o is 1 only when line sync is low and output disable is 0.
- R9: A mode write with d6 = 1 returns every register to its R1 value, whatever the other bits are. No soft-reset state remains afterwards.
- R10: While power-down is set, all other registers keep their values and can still be written. A mode write that clears power-down stores its other fields, but the signal configuration becomes 00. A later mode write sets the signal configuration normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_sync_i | input | 1 | Line sync; enables the serial port when high |
| ser_ld_i | input | 1 | Serial load strobe, active low |
| ser_clk_i | input | 1 | Serial bit clock |
| ser_dat_i | input | 1 | Serial data |
| gain_o | output | 18 | Packed colour gains, red in bits 5:0 |
| offset_o | output | 24 | Packed colour offsets, red in bits 7:0 |
| pwrdn_o | output | 1 | Power-down |
| ext_top_o | output | 1 | External top reference select |
| ext_dc_o | output | 1 | External DC reference select |
| ac_cpl_o | output | 1 | AC coupling select |
| invert_o | output | 1 | Inverted output polarity |
| sig_cfg_o | output | 2 | Signal configuration |
| out_dis_o | output | 1 | Output disable |
| ofs_rng_o | output | 1 | Offset range select |
| int_ref_o | output | 1 | Internal reference enable |
| test_o | output | 4 | Test enables |
| bus_oe_o | output | 1 | Pixel bus output enable |

## Verification
Suppose the bit counter drifts or the shift register is misaligned. The next committed word then lands in the wrong register or carries shifted data, and the error appears on a gain, offset or mode output within a dozen system clocks of the rising strobe. If a short frame leaks a write, or the soft reset leaves a register untouched, the error shows at the first full-state comparison after that frame. The bench compares the whole control state after every frame, so any such fault is reported at the frame that caused it.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

   // mode register field layout (bit positions decoded by the bank)
   localparam int MODE_PD_BIT   = 7;
   localparam int MODE_SRST_BIT = 6;

   typedef struct packed {
      logic       pd;
      logic       ext_top;
      logic       ext_dc;
      logic       ac_cpl;
      logic       invert;
      logic [1:0] cfg;
   } mode_t;

   typedef struct packed {
      logic       out_dis;
      logic       ofs_rng;
      logic       int_ref;
      logic [3:0] test;
   } test_t;

   localparam mode_t MODE_DEFAULT = '0;
   localparam test_t TEST_DEFAULT = '0;
   localparam logic [7:0] OFS_DEFAULT = 8'h40;

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ctl_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= '0;
            else        stage_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/ctl_ser_rx.sv
module ctl_ser_rx #(
   parameter int ADDR_W      = 3,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_i,
   input  logic              ld_i,
   input  logic              sclk_i,
   input  logic              sdat_i,
   output logic              commit_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o
);

   localparam int FRAME_BITS = ADDR_W + DATA_W;
   localparam int CNT_W      = $clog2(FRAME_BITS + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

   logic [3:0] pins_s;
   logic       sync_s, ld_s, sclk_s, sdat_s;
   logic       ld_prev_q, sclk_prev_q;
   logic       armed_q, commit_q;
   logic [CNT_W-1:0]      cnt_q;
   logic [FRAME_BITS-1:0] sh_q;
   logic       ld_fall, ld_rise, sclk_rise;

   ctl_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({sync_i, ld_i, sclk_i, sdat_i}),
      .q_o   (pins_s)
   );

   assign {sync_s, ld_s, sclk_s, sdat_s} = pins_s;
   assign ld_fall   =  ld_prev_q  & ~ld_s;
   assign ld_rise   = ~ld_prev_q  &  ld_s;
   assign sclk_rise = ~sclk_prev_q & sclk_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_prev_q   <= 1'b0;
         sclk_prev_q <= 1'b0;
         armed_q     <= 1'b0;
         commit_q    <= 1'b0;
         cnt_q       <= '0;
         sh_q        <= '0;
      end else begin
         ld_prev_q   <= ld_s;
         sclk_prev_q <= sclk_s;
         commit_q    <= 1'b0;
         if (!sync_s) begin
            armed_q <= 1'b0;
         end else if (ld_fall) begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
         end else if (ld_rise) begin
            armed_q  <= 1'b0;
            commit_q <= armed_q && (cnt_q == CNT_FULL);
         end else if (armed_q && !ld_s && sclk_rise && (cnt_q < CNT_FULL)) begin
            sh_q  <= {sh_q[FRAME_BITS-2:0], sdat_s};
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign commit_o = commit_q;
   assign addr_o   = sh_q[FRAME_BITS-1 -: ADDR_W];
   assign data_o   = sh_q[DATA_W-1:0];

   // R5
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_FULL);

   // R4
   commit_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_q |-> ($past(cnt_q) == CNT_FULL));

   // R6
   commit_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_q |-> $past(sync_s));

endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
   import ctl_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int DATA_W      = 8,
   parameter int GAIN_W      = 6,
   parameter int NUM_COLOURS = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [DATA_W-1:0]             wr_data,
   output logic [NUM_COLOURS*GAIN_W-1:0] gain_o,
   output logic [NUM_COLOURS*DATA_W-1:0] offset_o,
   output mode_t                         mode_o,
   output test_t                         test_o
);

   localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(2*NUM_COLOURS);
   localparam logic [ADDR_W-1:0] TEST_ADDR = ADDR_W'(2*NUM_COLOURS + 1);
   localparam logic [DATA_W-1:0] OFS_RST   = DATA_W'(OFS_DEFAULT);

   logic  soft_rst;
   logic  mode_wr;
   logic  pd_exit;
   mode_t mode_q;
   test_t test_q;

   assign mode_wr  = wr_en && (wr_addr == MODE_ADDR);
   assign soft_rst = mode_wr && wr_data[MODE_SRST_BIT];
   assign pd_exit  = mode_q.pd && !wr_data[MODE_PD_BIT];

   for (genvar c = 0; c < NUM_COLOURS; c++) begin : g_colour
      localparam logic [ADDR_W-1:0] GAIN_ADDR = ADDR_W'(2*c);
      localparam logic [ADDR_W-1:0] OFS_ADDR  = ADDR_W'(2*c + 1);
      logic [GAIN_W-1:0] gain_q;
      logic [DATA_W-1:0] ofs_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            gain_q <= '0;
            ofs_q  <= OFS_RST;
         end else if (soft_rst) begin
            gain_q <= '0;
            ofs_q  <= OFS_RST;
         end else if (wr_en) begin
            if (wr_addr == GAIN_ADDR) gain_q <= wr_data[DATA_W-1 -: GAIN_W];
            if (wr_addr == OFS_ADDR)  ofs_q  <= wr_data;
         end
      end

      assign gain_o[c*GAIN_W +: GAIN_W]   = gain_q;
      assign offset_o[c*DATA_W +: DATA_W] = ofs_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_DEFAULT;
         test_q <= TEST_DEFAULT;
      end else if (soft_rst) begin
         mode_q <= MODE_DEFAULT;
         test_q <= TEST_DEFAULT;
      end else begin
         if (mode_wr) begin
            mode_q.pd      <= wr_data[MODE_PD_BIT];
            mode_q.ext_top <= wr_data[5];
            mode_q.ext_dc  <= wr_data[4];
            mode_q.ac_cpl  <= wr_data[3];
            mode_q.invert  <= wr_data[2];
            mode_q.cfg     <= pd_exit ? 2'b00 : wr_data[1:0];
         end
         if (wr_en && (wr_addr == TEST_ADDR)) begin
            test_q <= test_t'(wr_data[6:0]);
         end
      end
   end

   assign mode_o = mode_q;
   assign test_o = test_q;

   // R9
   softrst_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (mode_q == MODE_DEFAULT && test_q == TEST_DEFAULT &&
                    offset_o[DATA_W-1:0] == OFS_RST && gain_o[GAIN_W-1:0] == '0));

   // R10
   pd_exit_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && !soft_rst && mode_q.pd && !wr_data[MODE_PD_BIT]) |=> (mode_q.cfg == 2'b00));

   // R4
   no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(mode_q) && $stable(test_q) && $stable(gain_o) && $stable(offset_o)));

endmodule

// File: rtl/ctl_regfile_top.sv
module ctl_regfile_top
   import ctl_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int DATA_W      = 8,
   parameter int GAIN_W      = 6,
   parameter int NUM_COLOURS = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          line_sync_i,
   input  logic                          ser_ld_i,
   input  logic                          ser_clk_i,
   input  logic                          ser_dat_i,
   output logic [NUM_COLOURS*GAIN_W-1:0] gain_o,
   output logic [NUM_COLOURS*DATA_W-1:0] offset_o,
   output logic                          pwrdn_o,
   output logic                          ext_top_o,
   output logic                          ext_dc_o,
   output logic                          ac_cpl_o,
   output logic                          invert_o,
   output logic [1:0]                    sig_cfg_o,
   output logic                          out_dis_o,
   output logic                          ofs_rng_o,
   output logic                          int_ref_o,
   output logic [3:0]                    test_o,
   output logic                          bus_oe_o
);

   if (DATA_W != 8) begin : g_bad_data_w
      $error("ctl_regfile_top: mode and test layouts need DATA_W == 8");
   end
   if (GAIN_W > DATA_W || GAIN_W < 1) begin : g_bad_gain_w
      $error("ctl_regfile_top: GAIN_W must lie in 1..DATA_W");
   end
   if (2*NUM_COLOURS + 2 > (1 << ADDR_W)) begin : g_bad_addr_w
      $error("ctl_regfile_top: address space too small for register map");
   end

   logic              commit;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   mode_t             mode;
   test_t             test;

   ctl_ser_rx #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_i   (line_sync_i),
      .ld_i     (ser_ld_i),
      .sclk_i   (ser_clk_i),
      .sdat_i   (ser_dat_i),
      .commit_o (commit),
      .addr_o   (wr_addr),
      .data_o   (wr_data)
   );

   ctl_reg_bank #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .GAIN_W      (GAIN_W),
      .NUM_COLOURS (NUM_COLOURS)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (commit),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .gain_o   (gain_o),
      .offset_o (offset_o),
      .mode_o   (mode),
      .test_o   (test)
   );

   assign pwrdn_o   = mode.pd;
   assign ext_top_o = mode.ext_top;
   assign ext_dc_o  = mode.ext_dc;
   assign ac_cpl_o  = mode.ac_cpl;
   assign invert_o  = mode.invert;
   assign sig_cfg_o = mode.cfg;
   assign out_dis_o = test.out_dis;
   assign ofs_rng_o = test.ofs_rng;
   assign int_ref_o = test.int_ref;
   assign test_o    = test.test;
   assign bus_oe_o  = !line_sync_i && !test.out_dis;

   // R6
   bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_sync_i |-> !bus_oe_o);

endmodule

// File: tb/ctl_regfile_top_bench.sv
module ctl_regfile_top_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_sync = 1'b0, ser_ld = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0;
   logic [17:0] gain_o;
   logic [23:0] offset_o;
   logic pwrdn_o, ext_top_o, ext_dc_o, ac_cpl_o, invert_o;
   logic [1:0] sig_cfg_o;
   logic out_dis_o, ofs_rng_o, int_ref_o, bus_oe_o;
   logic [3:0] test_o;

   int checks = 0;
   int errors = 0;

   logic [5:0] exp_gain [3];
   logic [7:0] exp_ofs  [3];
   logic [6:0] exp_mode;   // {pd, ext_top, ext_dc, ac, inv, cfg[1:0]}
   logic [6:0] exp_test;   // {out_dis, rng, iref, test[3:0]}

   always #4 clk = ~clk;

   ctl_regfile_top u_ctl_regfile_top (
      .clk(clk), .rst_n(rst_n), .line_sync_i(line_sync), .ser_ld_i(ser_ld),
      .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .gain_o(gain_o), .offset_o(offset_o),
      .pwrdn_o(pwrdn_o), .ext_top_o(ext_top_o), .ext_dc_o(ext_dc_o), .ac_cpl_o(ac_cpl_o),
      .invert_o(invert_o), .sig_cfg_o(sig_cfg_o), .out_dis_o(out_dis_o),
      .ofs_rng_o(ofs_rng_o), .int_ref_o(int_ref_o), .test_o(test_o), .bus_oe_o(bus_oe_o)
   );

   function automatic logic [55:0] exp_vec();
      return {exp_gain[2], exp_gain[1], exp_gain[0], exp_ofs[2], exp_ofs[1], exp_ofs[0],
              exp_mode, exp_test};
   endfunction

   function automatic logic [55:0] got_vec();
      return {gain_o, offset_o, pwrdn_o, ext_top_o, ext_dc_o, ac_cpl_o, invert_o,
              sig_cfg_o, out_dis_o, ofs_rng_o, int_ref_o, test_o};
   endfunction

   function automatic void model_defaults();
      for (int c = 0; c < 3; c++) begin
         exp_gain[c] = 6'd0;
         exp_ofs[c]  = 8'h40;
      end
      exp_mode = '0;
      exp_test = '0;
   endfunction

   function automatic void model_write(input logic [2:0] a, input logic [7:0] d);
      logic [1:0] cfg;
      if (a == 3'd6) begin
         if (d[6]) model_defaults();
         else begin
            cfg = (exp_mode[6] && !d[7]) ? 2'b00 : d[1:0];
            exp_mode = {d[7], d[5:2], cfg};
         end
      end else if (a == 3'd7) begin
         exp_test = d[6:0];
      end else if (a[0] == 1'b0) begin
         exp_gain[a[2:1]] = d[7:2];
      end else begin
         exp_ofs[a[2:1]] = d;
      end
   endfunction

   task automatic check(input string tag, input logic [55:0] got, input logic [55:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic check_state(input string tag);
      check(tag, got_vec(), exp_vec());
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // mode: 0 normal, 1 sync low for whole frame, 2 sync dropped mid-frame
   task automatic send_frame(input logic [2:0] a, input logic [7:0] d,
                             input int nclk, input int mode);
      logic [10:0] word;
      word = {a, d};
      line_sync = (mode != 1);
      wait_clk(4);
      ser_ld = 1'b0;
      wait_clk(4);
      for (int i = 0; i < nclk; i++) begin
         ser_dat = (i < 11) ? word[10-i] : 1'($urandom);
         wait_clk(4);
         ser_clk = 1'b1;
         wait_clk(4);
         ser_clk = 1'b0;
         if (mode == 2 && i == 5) begin
            line_sync = 1'b0;
            wait_clk(6);
            line_sync = 1'b1;
            wait_clk(4);
         end
      end
      wait_clk(4);
      ser_ld = 1'b1;
      wait_clk(12);
      checks++;
      if (mode != 1 && bus_oe_o !== 1'b0) begin
         errors++;
         $display("FAIL R6: bus_oe_o during sync actual %b expected 0", bus_oe_o);
      end
      line_sync = 1'b0;
      wait_clk(4);
      if (mode == 0 && nclk >= 11) model_write(a, d);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      model_defaults();
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      check_state("R1 reset defaults");
      checks++;
      if (bus_oe_o !== 1'b1) begin
         errors++;
         $display("FAIL R8: bus_oe_o idle actual %b expected 1", bus_oe_o);
      end

      // R2/R3: each colour register
      send_frame(3'd0, 8'b101101_11, 11, 0); check_state("R3 red gain drops d1..d0");
      send_frame(3'd1, 8'hA5, 11, 0);       check_state("R2 red offset");
      send_frame(3'd2, 8'hFC, 11, 0);       check_state("R3 green gain");
      send_frame(3'd3, 8'h01, 11, 0);       check_state("R3 green offset");
      send_frame(3'd4, 8'h04, 11, 0);       check_state("R3 blue gain");
      send_frame(3'd5, 8'hFF, 11, 0);       check_state("R3 blue offset");
      // R7 mode fields
      send_frame(3'd6, 8'b0011_1110, 11, 0); check_state("R7 mode fields");
      // R8 test fields and output disable
      send_frame(3'd7, 8'b0101_1010, 11, 0); check_state("R8 test fields");
      checks++;
      if (bus_oe_o !== 1'b0) begin
         errors++;
         $display("FAIL R8: bus_oe_o with out_dis actual %b expected 0", bus_oe_o);
      end
      send_frame(3'd7, 8'b0011_0101, 11, 0); check_state("R8 test fields clear disable");
      checks++;
      if (bus_oe_o !== 1'b1) begin
         errors++;
         $display("FAIL R8: bus_oe_o enabled actual %b expected 1", bus_oe_o);
      end
      // R4 short frames
      send_frame(3'd1, 8'h11, 10, 0); check_state("R4 ten clocks no write");
      send_frame(3'd3, 8'h22, 0, 0);  check_state("R4 zero clocks no write");
      // R5 extra clocks
      send_frame(3'd1, 8'h3C, 14, 0); check_state("R5 extra clocks ignored");
      // R6 sync low / dropped
      send_frame(3'd5, 8'h77, 11, 1); check_state("R6 sync low frame ignored");
      send_frame(3'd5, 8'h66, 11, 2); check_state("R6 sync drop discards frame");
      // R10 power-down
      send_frame(3'd6, 8'b1000_0011, 11, 0); check_state("R10 enter power-down");
      send_frame(3'd2, 8'h80, 11, 0);        check_state("R10 write during power-down");
      send_frame(3'd6, 8'b0000_0110, 11, 0); check_state("R10 exit clears cfg");
      send_frame(3'd6, 8'b0000_0110, 11, 0); check_state("R10 cfg reprogrammed");
      // R9 soft reset with other bits set
      send_frame(3'd6, 8'hFF, 11, 0); check_state("R9 soft reset restores defaults");
      send_frame(3'd6, 8'h00, 11, 0); check_state("R9 no lingering reset");

      // random mix
      for (int k = 0; k < 120; k++) begin
         logic [2:0] a;
         logic [7:0] d;
         int n, sel, m;
         a = 3'($urandom_range(0, 7));
         d = 8'($urandom);
         if (a == 3'd6 && ($urandom_range(0, 3) != 0)) d[6] = 1'b0;
         sel = $urandom_range(0, 9);
         n = (sel < 7) ? 11 : (sel == 7 ? $urandom_range(1, 10) : $urandom_range(12, 16));
         m = ($urandom_range(0, 11) == 0) ? $urandom_range(1, 2) : 0;
         send_frame(a, d, n, m);
         check_state("R2 R3 R4 R5 R6 R7 R8 R9 R10 random frame");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule